// File: doc/BRIEF.md
# SPI Slave Port with Deselect Restart and Status Flags

This block is the slave end of a four-wire serial link. It lives in the system clock domain: the serial clock, data-in and select pins are brought over by a synchronizer, edges of the serial clock are found by comparing successive synchronized samples, and data is captured on the rising edge and moved on the falling edge (clock mode 0). A CPU reaches it through a small register bus. It loads a transmit word, raises a ready flag, and later collects the received word and the event flags.

Transmit and receive each have their own 3-bit length code, so a word can be 1 to 8 bits long, and one control bit picks the bit order for both directions. If the receive buffer still holds an unread word when another one completes, the block flags an overflow instead of overwriting it. A restart option resets the port on every deselect. When it is set, releasing select drops any partial word and invalidates both buffered words. When it is clear, a partial word survives the deselect and carries on in the next select period.

Top module: `spi_slave_rs`

Register map (2-bit address): 0 = control (bits 2:0 transmit length code, bits 5:3 receive length code, bit 6 restart enable), 1 = status, 2 = transmit data, 3 = received data (read only). Read data appears on `reg_rdata` one clock after the address.

## Requirements
- R1: After reset, status reads 0x40, control and received data read 0, `irq` is 0 and `spi_miso` is 0.
- R2: A length code of 0 means 8 bits and codes 1 to 7 mean that many bits. A transfer uses the low n bits of the transmit word. A received word is right aligned in its low n bits, with the upper bits zero. Transmit and receive lengths act independently.
- R3: Status bit 6 selects the bit order for both directions: 1 sends and receives bit n-1 first, 0 sends and receives bit 0 first. It is read/write.
- R4: Writing 1 to status bit 3 (transmit ready) marks the transmit register as valid. Hardware clears the bit once the last bit of that word has been shifted out.
- R5: Status bit 4 (transmit event) is set when a valid transmit word is copied into the shifter, which happens at a word boundary while bit 3 is set.
- R6: When a receive word completes and status bit 1 (receive ready) is clear, the word is stored at address 3 and bits 1 and 2 (receive event) are set.
- R7: When a receive word completes while bit 1 is set, status bit 5 (overflow) is set and the stored word is kept. Writing 1 to bit 1 clears both bit 1 and bit 5.
- R8: With restart disabled, a partial word and a pending transmit word survive a deselect, and the word resumes in the next select period.
- R9: With restart enabled (control bit 6), releasing select sets status bit 7, clears bits 1, 3 and 5, and discards any partial word in both directions.
- R10: Bits 7, 4 and 2 are cleared by writing 1 to them, and writing 0 leaves them unchanged. `irq` is the OR of bits 4 and 2, registered one clock later.
- R11: With no valid transmit word loaded, the slave shifts out zeros. `spi_miso` is 0 and `spi_miso_oe` is 0 while the port is deselected.
- R12: Status bit 0 reads 1 while a receive word is partly shifted in, and 0 otherwise.
- R13: Serial clock edges while select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 8-bit words and a two-stage synchronizer. With 8-bit words every 3-bit length code can be reached, including code 0, whose wrap to a full 8-bit word is the least obvious case. The serial clock runs at ten system clocks per half period. That leaves room for the synchronizer and edge-detect latency before each rising edge, and lets the bench mix word lengths, bit orders and restart settings in random transfers. Directed cases cover overflow, deselect in the middle of a word with and without restart, unequal transmit and receive lengths, and clock activity while the port is deselected.

// File: rtl/spis_pkg.sv
package spis_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;

  // status bit positions (software decodes these)
  localparam int ST_REL   = 7;
  localparam int ST_MSB   = 6;
  localparam int ST_OVF   = 5;
  localparam int ST_TXIF  = 4;
  localparam int ST_TXRDY = 3;
  localparam int ST_RXIF  = 2;
  localparam int ST_RXRDY = 1;
  localparam int ST_BUSY  = 0;
endpackage

// File: rtl/spis_sync_edge.sv
module spis_sync_edge #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      prev <= pipe[STAGES-1];
    end
  end

  always_comb begin
    lvl  = pipe[STAGES-1];
    rise = lvl & ~prev;
    fall = ~lvl & prev;
  end
endmodule

// File: rtl/spis_tx_unit.sv
module spis_tx_unit #(
  parameter int DATA_W = 8,
  parameter int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              shift_edge,
  input  logic [CNT_W-1:0]  len_code,
  input  logic              msb_first,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_ready,
  output logic              load_evt,
  output logic              done_evt,
  output logic              out_bit
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              loaded;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  pos;
  logic              last;

  always_comb begin
    last_idx = len_code - ONE;   // code 0 wraps to DATA_W-1
    pos      = msb_first ? (last_idx - cnt) : cnt;
    last     = (cnt == last_idx);
    out_bit  = sr[pos];
    load_evt = !flush && !loaded && tx_ready && (cnt == '0) && !shift_edge;
    done_evt = !flush && shift_edge && last && loaded;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sr     <= '0;
      cnt    <= '0;
      loaded <= 1'b0;
    end else if (load_evt) begin
      sr     <= tx_word;
      loaded <= 1'b1;
    end else if (shift_edge) begin
      if (last) begin
        cnt <= '0;
        if (loaded) begin
          loaded <= 1'b0;
          sr     <= '0;
        end
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/spis_rx_unit.sv
module spis_rx_unit #(
  parameter int DATA_W = 8,
  parameter int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              sample_edge,
  input  logic [CNT_W-1:0]  len_code,
  input  logic              msb_first,
  input  logic              in_bit,
  output logic              done_evt,
  output logic [DATA_W-1:0] word,
  output logic              busy
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  pos;
  logic              last;
  logic [DATA_W-1:0] base;

  always_comb begin
    last_idx = len_code - ONE;
    pos      = msb_first ? (last_idx - cnt) : cnt;
    last     = (cnt == last_idx);
    base     = (cnt == '0) ? '0 : sr;
    word     = base;
    word[pos] = in_bit;
    done_evt = sample_edge && last && !flush;
    busy     = (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sr  <= '0;
      cnt <= '0;
    end else if (sample_edge) begin
      sr  <= word;
      cnt <= last ? '0 : cnt + ONE;
    end
  end
endmodule

// File: rtl/spi_slave_rs.sv
module spi_slave_rs #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              spi_sclk,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              irq
);
  import spis_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);
  localparam int CT_W  = 2 * CNT_W + 1;
  localparam int CT_RESTART = 2 * CNT_W;

  // pin synchronizer: bit2 select, bit1 data-in, bit0 clock
  logic [2:0] pin_lvl, pin_rise, pin_fall;
  spis_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .din({spi_ss_n, spi_mosi, spi_sclk}),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  logic ss_act, sclk_rise, sclk_fall, mosi_s, ss_release;
  always_comb begin
    ss_act     = ~pin_lvl[2];
    sclk_rise  = pin_rise[0] & ss_act;
    sclk_fall  = pin_fall[0] & ss_act;
    mosi_s     = pin_lvl[1];
    ss_release = pin_rise[2];
  end

  // registers
  logic [CT_W-1:0]   ctrl_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic rel_q, msb_q, ovf_q, txif_q, txrdy_q, rxif_q, rxrdy_q;

  logic restart_en, flush;
  logic [CNT_W-1:0] tx_len, rx_len;
  always_comb begin
    restart_en = ctrl_q[CT_RESTART];
    tx_len     = ctrl_q[CNT_W-1:0];
    rx_len     = ctrl_q[2*CNT_W-1:CNT_W];
    flush      = ss_release & restart_en;
  end

  logic tx_load, tx_done, tx_bit;
  spis_tx_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .flush(flush), .shift_edge(sclk_fall),
    .len_code(tx_len), .msb_first(msb_q), .tx_word(txd_q),
    .tx_ready(txrdy_q), .load_evt(tx_load), .done_evt(tx_done),
    .out_bit(tx_bit)
  );

  logic rx_done, rx_busy;
  logic [DATA_W-1:0] rx_word;
  spis_rx_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .flush(flush), .sample_edge(sclk_rise),
    .len_code(rx_len), .msb_first(msb_q), .in_bit(mosi_s),
    .done_evt(rx_done), .word(rx_word), .busy(rx_busy)
  );

  logic wr_ctrl, wr_stat, wr_txd, rxrdy_ack, rxrdy_eff;
  always_comb begin
    wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
    wr_stat   = reg_wr && (reg_addr == REG_STAT);
    wr_txd    = reg_wr && (reg_addr == REG_TXD);
    rxrdy_ack = wr_stat && reg_wdata[ST_RXRDY];
    rxrdy_eff = rxrdy_q && !rxrdy_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      txd_q   <= '0;
      rxd_q   <= '0;
      rel_q   <= 1'b0;
      msb_q   <= 1'b1;
      ovf_q   <= 1'b0;
      txif_q  <= 1'b0;
      txrdy_q <= 1'b0;
      rxif_q  <= 1'b0;
      rxrdy_q <= 1'b0;
    end else begin
      // CPU side first, hardware events override
      if (wr_ctrl) ctrl_q <= reg_wdata[CT_W-1:0];
      if (wr_txd)  txd_q  <= reg_wdata;
      if (wr_stat) begin
        msb_q <= reg_wdata[ST_MSB];
        if (reg_wdata[ST_REL])   rel_q   <= 1'b0;
        if (reg_wdata[ST_TXIF])  txif_q  <= 1'b0;
        if (reg_wdata[ST_TXRDY]) txrdy_q <= 1'b1;
        if (reg_wdata[ST_RXIF])  rxif_q  <= 1'b0;
        if (rxrdy_ack) begin
          rxrdy_q <= 1'b0;
          ovf_q   <= 1'b0;
        end
      end
      if (tx_load) txif_q  <= 1'b1;
      if (tx_done) txrdy_q <= 1'b0;
      if (rx_done) begin
        if (rxrdy_eff) begin
          ovf_q <= 1'b1;
        end else begin
          rxd_q   <= rx_word;
          rxrdy_q <= 1'b1;
          rxif_q  <= 1'b1;
        end
      end
      if (flush) begin
        rel_q   <= 1'b1;
        txrdy_q <= 1'b0;
        rxrdy_q <= 1'b0;
        ovf_q   <= 1'b0;
      end
    end
  end

  // registered outputs
  logic [DATA_W-1:0] stat_v, rd_next;
  always_comb begin
    stat_v           = '0;
    stat_v[ST_REL]   = rel_q;
    stat_v[ST_MSB]   = msb_q;
    stat_v[ST_OVF]   = ovf_q;
    stat_v[ST_TXIF]  = txif_q;
    stat_v[ST_TXRDY] = txrdy_q;
    stat_v[ST_RXIF]  = rxif_q;
    stat_v[ST_RXRDY] = rxrdy_q;
    stat_v[ST_BUSY]  = rx_busy;
    rd_next = '0;
    case (reg_addr)
      REG_CTRL: rd_next[CT_W-1:0] = ctrl_q;
      REG_STAT: rd_next = stat_v;
      REG_TXD:  rd_next = txd_q;
      default:  rd_next = rxd_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata   <= '0;
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
      irq         <= 1'b0;
    end else begin
      reg_rdata   <= rd_next;
      spi_miso    <= ss_act & tx_bit;
      spi_miso_oe <= ss_act;
      irq         <= txif_q | rxif_q;
    end
  end
endmodule

// File: rtl/spis_checker.sv
module spis_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ss_act,
  input logic              ss_release,
  input logic              restart_en,
  input logic              rel,
  input logic              ovf,
  input logic              txrdy,
  input logic              rxrdy,
  input logic              txif,
  input logic              rxif,
  input logic [DATA_W-1:0] rxd,
  input logic              irq,
  input logic              miso,
  input logic              miso_oe
);
  // R7: overflow only exists alongside an unread word
  a_r7_ovf_needs_ready: assert property (@(posedge clk) disable iff (rst)
    ovf |-> rxrdy);

  // R6: a newly stored word always raises the receive event
  a_r6_ready_with_event: assert property (@(posedge clk) disable iff (rst)
    $rose(rxrdy) |-> rxif);

  // R9: release with restart flushes and flags
  a_r9_release_flush: assert property (@(posedge clk) disable iff (rst)
    (ss_release && restart_en) |=> (rel && !rxrdy && !txrdy && !ovf));

  // R10: interrupt follows the event flags one clock later
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == $past(txif || rxif));

  // R11: output quiet while not driven
  a_r11_miso_quiet: assert property (@(posedge clk) disable iff (rst)
    !miso_oe |-> !miso);

  // R13: nothing is received while deselected
  a_r13_no_rx_idle: assert property (@(posedge clk) disable iff (rst)
    !ss_act |=> $stable(rxd));
endmodule

bind spi_slave_rs spis_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ss_act(ss_act), .ss_release(ss_release),
  .restart_en(restart_en), .rel(rel_q), .ovf(ovf_q), .txrdy(txrdy_q),
  .rxrdy(rxrdy_q), .txif(txif_q), .rxif(rxif_q), .rxd(rxd_q),
  .irq(irq), .miso(spi_miso), .miso_oe(spi_miso_oe)
);

// File: tb/tb_spi_slave_rs.sv
module tb_spi_slave_rs;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic spi_sclk = 1'b0;
  logic spi_ss_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_slave_rs dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic set_ss(input logic v);
    @(negedge clk);
    spi_ss_n = v;
    wait_half();
  endtask

  // seq bit i is the i-th bit on the wire
  task automatic clk_bits(input int n, input logic [7:0] mseq, output logic [7:0] sseq);
    sseq = 8'd0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      spi_mosi = mseq[i];
      wait_half();
      sseq[i] = spi_miso;
      spi_sclk = 1'b1;
      wait_half();
      spi_sclk = 1'b0;
    end
    wait_half();
  endtask

  function automatic int nbits(input int code);
    return (code == 0) ? 8 : code;
  endfunction

  function automatic logic [7:0] exp_wire(input logic [7:0] data, input int n, input bit msb);
    logic [7:0] s = 8'd0;
    for (int i = 0; i < n; i++) s[i] = msb ? data[n-1-i] : data[i];
    return s;
  endfunction

  function automatic logic [7:0] exp_word(input logic [7:0] seq, input int n, input bit msb);
    logic [7:0] w = 8'd0;
    for (int i = 0; i < n; i++) w[msb ? n-1-i : i] = seq[i];
    return w;
  endfunction

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d, s1, s2, mo, txv;
    int code, n;
    bit msb, rs;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(2'd1, d); chk("R1 status", d, 8'h40);
    rd(2'd0, d); chk("R1 control", d, 8'h00);
    rd(2'd3, d); chk("R1 rxdata", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 miso", spi_miso, 0);

    // R11 idle word: nothing loaded, zeros on the wire; R6 receive
    set_ss(1'b0);
    chk("R11 oe while selected", spi_miso_oe, 1);
    clk_bits(8, 8'hB2, s1);
    chk("R11 idle zeros", s1, 8'h00);
    rd(2'd1, d); chk("R6 status after idle word", d, 8'h46);
    rd(2'd3, d); chk("R6 rxdata msb-first", d, exp_word(8'hB2, 8, 1));
    set_ss(1'b1);
    chk("R11 oe deselected", spi_miso_oe, 0);
    wr(2'd1, 8'hD6);

    // R7 overflow with 4-bit words
    wr(2'd0, 8'h24);
    set_ss(1'b0);
    clk_bits(4, 8'h0A, s1);
    clk_bits(4, 8'h05, s1);
    set_ss(1'b1);
    rd(2'd1, d); chk("R7 overflow status", d, 8'h66);
    rd(2'd3, d); chk("R7 first word kept", d, exp_word(8'h0A, 4, 1));
    wr(2'd1, 8'h42);
    rd(2'd1, d); chk("R7 ack clears overflow", d, 8'h44);
    // R10 write-0 leaves flags, write-1 clears
    chk("R10 irq set", irq, 1);
    wr(2'd1, 8'h40);
    rd(2'd1, d); chk("R10 write 0 no effect", d, 8'h44);
    wr(2'd1, 8'h44);
    rd(2'd1, d); chk("R10 w1c", d, 8'h40);
    chk("R10 irq clear", irq, 0);

    // R8 no restart: partial word resumes
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hC5);
    wr(2'd1, 8'h48);
    rd(2'd1, d); chk("R5 load sets event", d, 8'h58);
    set_ss(1'b0);
    clk_bits(3, 8'h05, s1);
    set_ss(1'b1);
    rd(2'd1, d); chk("R8 state held over deselect", d, 8'h59);
    set_ss(1'b0);
    clk_bits(5, 8'h1C, s2);
    set_ss(1'b1);
    chk("R8 resumed tx", {s2[4:0], s1[2:0]}, exp_wire(8'hC5, 8, 1));
    rd(2'd3, d); chk("R8 resumed rx", d, exp_word({3'b111, 5'h05}, 8, 1));
    rd(2'd1, d); chk("R4 ready cleared after send", d, 8'h56);
    wr(2'd1, 8'hD6);

    // R9/R12 restart: deselect mid-word flushes
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h3C);
    wr(2'd1, 8'h48);
    set_ss(1'b0);
    clk_bits(3, 8'h07, s1);
    rd(2'd1, d); chk("R12 busy mid word", d, 8'h59);
    set_ss(1'b1);
    rd(2'd1, d); chk("R9 flush on release", d, 8'hD0);
    wr(2'd1, 8'hD6);
    wr(2'd2, 8'h96);
    wr(2'd1, 8'h48);
    set_ss(1'b0);
    clk_bits(8, 8'h4D, s1);
    chk("R9 fresh tx after flush", s1, exp_wire(8'h96, 8, 1));
    rd(2'd3, d); chk("R9 fresh rx after flush", d, exp_word(8'h4D, 8, 1));
    set_ss(1'b1);
    wr(2'd1, 8'hD6);

    // R13 clock while deselected
    wr(2'd0, 8'h00);
    clk_bits(5, 8'h1F, s1);
    rd(2'd1, d); chk("R13 no effect deselected", d, 8'h40);
    rd(2'd3, d); chk("R13 rxdata unchanged", d, exp_word(8'h4D, 8, 1));

    // R2 unequal lengths: tx 8 bits, rx 4 bits
    wr(2'd0, 8'h20);
    wr(2'd2, 8'hE1);
    wr(2'd1, 8'h48);
    set_ss(1'b0);
    clk_bits(4, 8'h09, s1);
    rd(2'd3, d); chk("R2 short rx word", d, exp_word(8'h09, 4, 1));
    rd(2'd1, d); chk("R2 tx still pending", d & 8'h0A, 8'h0A);
    wr(2'd1, 8'h42);
    clk_bits(4, 8'h06, s2);
    chk("R2 full tx across two rx words", {s2[3:0], s1[3:0]}, exp_wire(8'hE1, 8, 1));
    rd(2'd1, d); chk("R4 tx ready cleared", d & 8'h08, 8'h00);
    set_ss(1'b1);
    wr(2'd1, 8'hD6);

    // random transfers: R2, R3, R4, R5, R6, R9, R10
    for (int it = 0; it < 24; it++) begin
      code = $urandom_range(0, 7);
      n    = nbits(code);
      msb  = 1'($urandom_range(0, 1));
      rs   = 1'($urandom_range(0, 1));
      txv  = 8'($urandom);
      mo   = 8'($urandom);
      wr(2'd0, {1'b0, rs, 3'(code), 3'(code)});
      wr(2'd1, {1'b0, msb, 6'h00});
      wr(2'd2, txv);
      wr(2'd1, {1'b0, msb, 6'h08});
      set_ss(1'b0);
      clk_bits(n, mo, s1);
      chk("R3 tx order and length", s1, exp_wire(txv, n, msb));
      rd(2'd3, d); chk("R2 rx word aligned", d, exp_word(mo, n, msb));
      rd(2'd1, d); chk("R5 status after transfer", d, {1'b0, msb, 6'h16});
      chk("R10 irq raised", irq, 1);
      set_ss(1'b1);
      rd(2'd1, d);
      chk("R9 release by mode", d, rs ? {1'b1, msb, 6'h14} : {1'b0, msb, 6'h16});
      wr(2'd1, {1'b1, msb, 6'h16});
    end

    done = 1'b1;
    finish_run();
  end
endmodule